// File: doc/BRIEF.md
# USB Bus Event Interrupt Detector

This block watches the sampled levels of the two USB data lines and turns timed line conditions into sticky interrupt flags. A reset is recognised when both lines sit low for a set number of milliseconds. A suspend is recognised when the idle (J) state persists without any change for a few milliseconds. A resume is recognised only while the bus is suspended, when a K state ends after lasting a time inside a fixed window. A second flag register collects one flag per endpoint, each set by a one-cycle event pulse from the endpoint logic.

All flags are write-1-to-clear through a small register port with combinational reads. An enable register masks each flag, and one interrupt output is the OR of the enabled flags. The millisecond timebase comes from a prescaler of `CLKS_PER_MS` clock cycles. The prescaler and the millisecond count restart on every change of the line state. A change of line state is the only thing that counts as bus activity.

A two-state machine tracks the bus mode. In BUS_ACTIVE, the transition *idle timeout* moves to BUS_SUSPENDED. In BUS_SUSPENDED, either the transition *resume accepted* (a K state of valid length ends) or *bus reset* (SE0 timeout) returns to BUS_ACTIVE. Every other condition leaves the mode unchanged.

Top module: `usb_bus_evt_irq`

## Requirements
- R1: After reset, both flag registers read 0, the enable register reads 0x3E (suspend disabled, everything else enabled), `irq` is 0 and the mode is BUS_ACTIVE.
- R2: Address 0 reads the bus flags with suspend in bit 0, resume in bit 1 and reset in bit 2. All higher bits read 0, and address 3 reads 0.
- R3: Once SE0 ({dp,dn}=00) has been sampled on RESET_MS×CLKS_PER_MS consecutive clock edges, the reset flag is set. It is set only once per unbroken SE0 period.
- R4: In BUS_ACTIVE, once J ({dp,dn}=10) has been sampled on IDLE_MS×CLKS_PER_MS consecutive edges, the suspend flag is set and the mode becomes BUS_SUSPENDED.
- R5: In BUS_SUSPENDED, when a K state ({dp,dn}=01) ends after a whole number of elapsed milliseconds between RSM_MIN_MS and RSM_MAX_MS inclusive, the resume flag is set and the mode becomes BUS_ACTIVE. A K state that is shorter or longer sets nothing.
- R6: In BUS_ACTIVE, a K state of any length never sets the resume flag.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event and a clear write hit the same bit in the same cycle, the set wins.
- R8: Address 1 holds the endpoint flags, with EP0, EP1 and EP2 in bits 0, 1 and 2. Each bit is set by the matching bit of `ep_evt`.
- R9: Address 2 is the enable register: bits 2:0 enable the bus flags in R2 order, and bits 5:3 enable endpoints 0 to 2. `irq` is high exactly when some flag and its enable bit are both 1.
- R10: A bus reset detected in BUS_SUSPENDED returns the mode to BUS_ACTIVE.
- R11: Any change of line state restarts all duration timing, so an interrupted SE0 must last its full time again before the reset flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_dp | input | 1 | Sampled D+ level |
| line_dn | input | 1 | Sampled D- level |
| ep_evt | input | N_EP | One-cycle endpoint event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the resume window. The bench must first hold J long enough to enter suspend, then produce K states whose lengths fall below, above and inside the window, and end each one with a change. A K state of valid length is also replayed after the mode has gone back to active, and after a reset taken from suspend, to show that it is ignored there. With a small `CLKS_PER_MS`, all of these durations fit in a few hundred cycles. A behavioural model counts edges since the last change and checks every cycle against it.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    typedef enum logic {
        BUS_ACTIVE    = 1'b0,
        BUS_SUSPENDED = 1'b1
    } bus_mode_e;

    localparam int FLG_SUSPEND = 0;
    localparam int FLG_RESUME  = 1;
    localparam int FLG_RESET   = 2;
    localparam int N_BUS_FLAGS = 3;

    localparam int ADDR_BUS = 0;
    localparam int ADDR_EP  = 1;
    localparam int ADDR_EN  = 2;

endpackage

// File: rtl/line_timer.sv
module line_timer #(
    parameter int CLKS_PER_MS = 12000,
    parameter int MS_SAT      = 16,
    localparam int MS_W       = $clog2(MS_SAT + 1),
    localparam int PRESC_W    = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      line_in,
    output logic [1:0]      line_q,
    output logic            line_chg,
    output logic            ms_tick,
    output logic [MS_W-1:0] ms_cnt
);
    import usb_evt_pkg::*;

    logic [PRESC_W-1:0] presc_q;

    assign line_chg = (line_in != line_q);
    assign ms_tick  = !line_chg && (presc_q == PRESC_W'(CLKS_PER_MS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= LS_J;
            presc_q <= '0;
            ms_cnt  <= '0;
        end else begin
            line_q <= line_in;
            if (line_chg) begin
                presc_q <= '0;
                ms_cnt  <= '0;
            end else if (ms_tick) begin
                presc_q <= '0;
                if (ms_cnt != MS_W'(MS_SAT))
                    ms_cnt <= ms_cnt + MS_W'(1);
            end else begin
                presc_q <= presc_q + PRESC_W'(1);
            end
        end
    end

    assert_ms_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_cnt != $past(ms_cnt)) |-> (ms_cnt == '0 || ms_cnt == $past(ms_cnt) + MS_W'(1)));

endmodule

// File: rtl/bus_event_fsm.sv
module bus_event_fsm
    import usb_evt_pkg::*;
#(
    parameter int MS_W       = 5,
    parameter int RESET_MS   = 10,
    parameter int IDLE_MS    = 3,
    parameter int RSM_MIN_MS = 10,
    parameter int RSM_MAX_MS = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      line_q,
    input  logic            line_chg,
    input  logic            ms_tick,
    input  logic [MS_W-1:0] ms_cnt,
    output logic            ev_suspend,
    output logic            ev_resume,
    output logic            ev_reset,
    output bus_mode_e       mode
);
    bus_mode_e mode_d;
    logic      idle_timeout;
    logic      k_in_window;
    logic      se0_timeout;

    assign se0_timeout  = ms_tick && (line_q == LS_SE0) && (ms_cnt == MS_W'(RESET_MS - 1));
    assign idle_timeout = ms_tick && (line_q == LS_J)   && (ms_cnt == MS_W'(IDLE_MS - 1));
    assign k_in_window  = line_chg && (line_q == LS_K)
                        && (ms_cnt >= MS_W'(RSM_MIN_MS)) && (ms_cnt <= MS_W'(RSM_MAX_MS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= BUS_ACTIVE;
        else        mode <= mode_d;
    end

    always_comb begin
        mode_d = mode;
        unique case (mode)
            BUS_ACTIVE:    if (idle_timeout) mode_d = BUS_SUSPENDED;
            BUS_SUSPENDED: if (k_in_window || se0_timeout) mode_d = BUS_ACTIVE;
        endcase
    end

    always_comb begin
        ev_reset   = se0_timeout;
        ev_suspend = 1'b0;
        ev_resume  = 1'b0;
        unique case (mode)
            BUS_ACTIVE:    ev_suspend = idle_timeout;
            BUS_SUSPENDED: ev_resume  = k_in_window;
        endcase
    end

endmodule

// File: rtl/w1c_flag_bank.sv
module w1c_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
        assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> (flags[i] == $past(flags[i])));
    end

endmodule

// File: rtl/usb_bus_evt_irq.sv
module usb_bus_evt_irq
    import usb_evt_pkg::*;
#(
    parameter int CLKS_PER_MS = 12000,
    parameter int RESET_MS    = 10,
    parameter int IDLE_MS     = 3,
    parameter int RSM_MIN_MS  = 10,
    parameter int RSM_MAX_MS  = 15,
    parameter int N_EP        = 3,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_dp,
    input  logic              line_dn,
    input  logic [N_EP-1:0]   ep_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int MS_SAT = RSM_MAX_MS + 1;
    localparam int MS_W   = $clog2(MS_SAT + 1);
    localparam int EN_W   = N_BUS_FLAGS + N_EP;
    localparam logic [EN_W-1:0] EN_RESET =
        {{N_EP{1'b1}}, {(N_BUS_FLAGS-1){1'b1}}, 1'b0};

    logic [1:0]             line_q;
    logic                   line_chg;
    logic                   ms_tick;
    logic [MS_W-1:0]        ms_cnt;
    logic                   ev_suspend, ev_resume, ev_reset;
    bus_mode_e              mode;
    logic [N_BUS_FLAGS-1:0] bus_set, bus_clr, bus_flags;
    logic [N_EP-1:0]        ep_clr, ep_flags;
    logic [EN_W-1:0]        irq_en;
    logic                   unused_wdata;

    line_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_SAT(MS_SAT)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_in({line_dp, line_dn}),
        .line_q(line_q), .line_chg(line_chg), .ms_tick(ms_tick), .ms_cnt(ms_cnt)
    );

    bus_event_fsm #(
        .MS_W(MS_W), .RESET_MS(RESET_MS), .IDLE_MS(IDLE_MS),
        .RSM_MIN_MS(RSM_MIN_MS), .RSM_MAX_MS(RSM_MAX_MS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_q(line_q), .line_chg(line_chg),
        .ms_tick(ms_tick), .ms_cnt(ms_cnt), .ev_suspend(ev_suspend),
        .ev_resume(ev_resume), .ev_reset(ev_reset), .mode(mode)
    );

    always_comb begin
        bus_set              = '0;
        bus_set[FLG_SUSPEND] = ev_suspend;
        bus_set[FLG_RESUME]  = ev_resume;
        bus_set[FLG_RESET]   = ev_reset;
    end

    assign bus_clr = (reg_wr && reg_addr == ADDR_W'(ADDR_BUS)) ? reg_wdata[N_BUS_FLAGS-1:0] : '0;
    assign ep_clr  = (reg_wr && reg_addr == ADDR_W'(ADDR_EP))  ? reg_wdata[N_EP-1:0]        : '0;

    w1c_flag_bank #(.N(N_BUS_FLAGS)) u_bus_flags (
        .clk(clk), .rst_n(rst_n), .set(bus_set), .clr(bus_clr), .flags(bus_flags)
    );

    w1c_flag_bank #(.N(N_EP)) u_ep_flags (
        .clk(clk), .rst_n(rst_n), .set(ep_evt), .clr(ep_clr), .flags(ep_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_en <= EN_RESET;
        else if (reg_wr && reg_addr == ADDR_W'(ADDR_EN))
            irq_en <= reg_wdata[EN_W-1:0];
    end

    assign unused_wdata = ^reg_wdata[DATA_W-1:EN_W];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADDR_BUS): reg_rdata[N_BUS_FLAGS-1:0] = bus_flags;
            ADDR_W'(ADDR_EP):  reg_rdata[N_EP-1:0]        = ep_flags;
            ADDR_W'(ADDR_EN):  reg_rdata[EN_W-1:0]        = irq_en;
            default:           reg_rdata = '0;
        endcase
    end

    assign irq = |({ep_flags, bus_flags} & irq_en);

    assert_reset_se0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_flags[FLG_RESET]) |-> ($past({line_dp, line_dn}) == 2'b00));
    assert_suspend_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_flags[FLG_SUSPEND]) |-> (mode == BUS_SUSPENDED));
    assert_resume_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_flags[FLG_RESUME]) |-> (mode == BUS_ACTIVE));
    assert_resume_needs_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_flags[FLG_RESUME]) |-> ($past(mode) == BUS_SUSPENDED));

endmodule

// File: tb/test_usb_bus_evt_irq.sv
module test_usb_bus_evt_irq;
    localparam int CLK_PERIOD = 10;
    localparam int CPM  = 4;
    localparam int RMS  = 10;
    localparam int IMS  = 3;
    localparam int KMIN = 10;
    localparam int KMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_dp = 1'b1;
    logic        line_dn = 1'b0;
    logic [2:0]  ep_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bus_evt_irq #(.CLKS_PER_MS(CPM), .RESET_MS(RMS), .IDLE_MS(IMS),
                      .RSM_MIN_MS(KMIN), .RSM_MAX_MS(KMAX)) i_usb_bus_evt_irq (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dn(line_dn),
        .ep_evt(ep_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [1:0] m_prev;
    int         m_cnt;
    bit         m_susp;
    logic [2:0] m_bus, m_ep;
    logic [5:0] m_en;

    always @(posedge clk) begin
        logic [1:0] ls;
        bit chg, e_rst, e_idle, e_k;
        logic [2:0] bset;
        if (!rst_n) begin
            m_prev = 2'b10; m_cnt = 0; m_susp = 0;
            m_bus = '0; m_ep = '0; m_en = 6'h3E;
        end else begin
            ls     = {line_dp, line_dn};
            chg    = (ls != m_prev);
            e_rst  = !chg && m_prev == 2'b00 && (m_cnt + 1) == RMS * CPM;
            e_idle = !chg && m_prev == 2'b10 && (m_cnt + 1) == IMS * CPM;
            e_k    = chg && m_prev == 2'b01 && (m_cnt / CPM) >= KMIN && (m_cnt / CPM) <= KMAX;
            bset   = {e_rst, e_k && m_susp, e_idle && !m_susp};
            if (reg_wr && reg_addr == 2'd0) m_bus = m_bus & ~reg_wdata[2:0];
            if (reg_wr && reg_addr == 2'd1) m_ep  = m_ep  & ~reg_wdata[2:0];
            if (reg_wr && reg_addr == 2'd2) m_en  = reg_wdata[5:0];
            m_bus = m_bus | bset;
            m_ep  = m_ep | ep_evt;
            if (!m_susp && e_idle)              m_susp = 1;
            else if (m_susp && (e_k || e_rst)) m_susp = 0;
            m_cnt  = chg ? 0 : m_cnt + 1;
            m_prev = ls;
        end
    end

    function automatic logic [15:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return {13'd0, m_bus};
            2'd1:    return {13'd0, m_ep};
            2'd2:    return {10'd0, m_en};
            default: return 16'd0;
        endcase
    endfunction

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (irq !== |({m_ep, m_bus} & m_en)) begin
                fails++;
                $display("FAIL R9 model irq: got %0b expected %0b", irq, |({m_ep, m_bus} & m_en));
            end
            checks++;
            if (reg_rdata !== model_read(reg_addr)) begin
                fails++;
                $display("FAIL %s model read addr %0d: got %h expected %h",
                         (reg_addr == 2'd1) ? "R8" : (reg_addr == 2'd2) ? "R9" : "R2",
                         reg_addr, reg_rdata, model_read(reg_addr));
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic hold(input logic [1:0] ls, input int n);
        {line_dp, line_dn} = ls;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, reg_rdata, exp);
        end
        step();
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: got %0b expected %0b", tag, irq, exp);
        end
        step();
    endtask

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] KST = 2'b01;
    localparam logic [1:0] JST = 2'b10;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        expect_reg(2'd0, 16'h0000, "R1");
        expect_reg(2'd1, 16'h0000, "R1");
        expect_reg(2'd2, 16'h003E, "R1");
        expect_irq(1'b0, "R1");

        // R4: idle J enters suspend; suspend not enabled so no irq
        hold(JST, 15);
        expect_reg(2'd0, 16'h0001, "R4");
        expect_irq(1'b0, "R9");
        wr(2'd2, 16'h003F);
        expect_irq(1'b1, "R9");
        wr(2'd0, 16'h0000);
        expect_reg(2'd0, 16'h0001, "R7");
        wr(2'd0, 16'h0001);
        expect_reg(2'd0, 16'h0000, "R7");

        // R5: K too short, K too long, then K inside the window
        hold(KST, 20); hold(JST, 5);
        expect_reg(2'd0, 16'h0000, "R5");
        hold(KST, 70); hold(JST, 5);
        expect_reg(2'd0, 16'h0000, "R5");
        hold(KST, 50); hold(SE0, 3);
        expect_reg(2'd0, 16'h0002, "R5");

        // R6: valid K while active does nothing
        wr(2'd0, 16'h0007);
        hold(KST, 50); hold(SE0, 3);
        expect_reg(2'd0, 16'h0000, "R6");

        // R11 then R3: broken SE0 must restart
        hold(SE0, 30); hold(JST, 1); hold(SE0, 30);
        expect_reg(2'd0, 16'h0000, "R11");
        hold(SE0, 15);
        expect_reg(2'd0, 16'h0004, "R3");
        wr(2'd0, 16'h0004);
        hold(SE0, 50);
        expect_reg(2'd0, 16'h0000, "R3");

        // R10: reset from suspend returns to active
        hold(JST, 15);
        hold(SE0, 45);
        expect_reg(2'd0, 16'h0005, "R10");
        wr(2'd0, 16'h0007);
        hold(KST, 50); hold(SE0, 3);
        expect_reg(2'd0, 16'h0000, "R10");

        // R8 endpoint flags, R7 set wins, R9 masking
        ep_evt = 3'b101; step(); ep_evt = 3'b000;
        expect_reg(2'd1, 16'h0005, "R8");
        expect_irq(1'b1, "R9");
        wr(2'd1, 16'h0001);
        expect_reg(2'd1, 16'h0004, "R8");
        ep_evt = 3'b100;
        wr(2'd1, 16'h0004);
        ep_evt = 3'b000;
        expect_reg(2'd1, 16'h0004, "R7");
        wr(2'd2, 16'h0000);
        expect_irq(1'b0, "R9");
        expect_reg(2'd2, 16'h0000, "R9");

        // R2: upper bits and unused address
        wr(2'd0, 16'hFFFF);
        expect_reg(2'd0, 16'h0000, "R2");
        expect_reg(2'd3, 16'h0000, "R2");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule